// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This block supervises software by counting down toward a forced system reset. A free-running prescaler divides the timer clock by a power of two chosen from eight settings. Each time the chosen division point is reached, an 8-bit main counter decrements once. If that counter is already at zero when a decrement is due, the block raises a one-cycle reset request and sets a sticky timeout flag. It also reloads the counter from the autoload register and restarts the prescaler.

Software keeps the system alive by feeding the watchdog. A feed is a two-write unlock: first write A5H to the first key register, and make the very next register access a write of 5AH to the second key register. A valid feed reloads the counter, restarts the prescaler and applies the control value that software staged earlier. Control changes, including stopping the watchdog, have no effect until that moment. If the first key is correct and the second key write carries the wrong data, the block asks for a reset at once.

The host side is a simple write strobe with a 2-bit address and 8-bit data. A separate pulse marks any other register access in the system, which cancels a half-finished feed.

Top module: `wdog_keyed`

## Requirements
- R1: While `rst_n` is low and on release, `sys_rst_req` and `timeout_flag` are 0. The active and staged control are 87H (running, select 7), the autoload value is 0, the prescaler is 0 and the counter is loaded with 0.
- R2: The tick divisor is 2^(BASE_LOG+sel), where sel is control bits [2:0]. With the default BASE_LOG=5, codes 0 to 7 give 32, 64, 128, 256, 512, 1024, 2048 and 4096.
- R3: A tick that arrives while the counter is 0 is an underflow. In the next cycle `sys_rst_req` is high for that cycle, and the counter reloads from the autoload value with the prescaler cleared. With no feed, requests repeat every divisor × (autoload + 1) cycles.
- R4: Any reset request sets `timeout_flag`, which then stays at 1 until `rst_n` goes low. Reset clears it even in the cycle an underflow occurs.
- R5: Address map: 0 is control, 1 is autoload, 2 is the first key and 3 is the second key. A write of A5H to address 2 arms a feed. If the next access is a write of 5AH to address 3, the feed is valid: the counter reloads, the prescaler clears, and the staged control becomes active.
- R6: A control write only stages a value; the active control changes only on a valid feed. An autoload write is used at the next reload, whether that reload comes from a feed or from an underflow.
- R7: Control bit 7 is the run bit. When a feed activates a control value whose bit 7 is 0, the prescaler and counter freeze and no underflow request occurs.
- R8: When a feed is armed and the next access writes address 3 with data other than 5AH, `sys_rst_req` is high in the following cycle.
- R9: Any other access while a feed is armed disarms it without a request: `other_acc`, or a write to address 0, 1 or 2 other than A5H to address 2. A later 5AH write to address 3 then neither feeds nor resets.
- R10: A write to address 3 while no feed is armed is ignored.
- R11: A valid feed in the same cycle as an underflow tick takes precedence, and no reset request results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous external reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 autoload, 2 key one, 3 key two) |
| wr_data | input | 8 | Write data |
| other_acc | input | 1 | Pulse for an access to any register outside this block |
| sys_rst_req | output | 1 | One-cycle system reset request |
| timeout_flag | output | 1 | Sticky flag showing that a watchdog reset was requested |

## Verification
The bench builds the block with BASE_LOG=1, so the divisors run from 2 to 256 cycles instead of 32 to 4096. This keeps the full-divisor reset timeout and every tap select within a short run. A small autoload makes underflows frequent enough to land a feed exactly on a tick. All key-sequence orderings are exercised: bad second key, intervening access, unarmed second key and stop-by-feed. A reference model checks both outputs on every cycle.

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int BASE_LOG = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       other_acc,
  output logic       sys_rst_req,
  output logic       timeout_flag
);
  localparam int PRE_W = BASE_LOG + 8;
  localparam logic [1:0] A_CTRL = 2'd0, A_LOAD = 2'd1, A_KEY1 = 2'd2, A_KEY2 = 2'd3;
  localparam logic [7:0] KEY1 = 8'hA5, KEY2 = 8'h5A, CTRL_RST = 8'h87;

  logic [PRE_W-1:0] pre, mask;
  logic [7:0] cnt, load, ctrl_act, ctrl_pend;
  logic armed, req_q, flag_q;

  wire key1     = wr_en && wr_addr == A_KEY1 && wr_data == KEY1;
  wire key2_wr  = armed && wr_en && wr_addr == A_KEY2;
  wire feed_ok  = key2_wr && wr_data == KEY2;
  wire feed_bad = key2_wr && wr_data != KEY2;
  wire run      = ctrl_act[7];

  assign mask = (PRE_W'(1) << (BASE_LOG + int'(ctrl_act[2:0]))) - PRE_W'(1);

  wire tick  = run && ((pre & mask) == mask);
  wire under = tick && cnt == 8'd0 && !feed_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre       <= '0;
      cnt       <= 8'd0;
      load      <= 8'd0;
      ctrl_act  <= CTRL_RST;
      ctrl_pend <= CTRL_RST;
      armed     <= 1'b0;
      req_q     <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_CTRL) ctrl_pend <= wr_data;
      if (wr_en && wr_addr == A_LOAD) load <= wr_data;
      armed <= key1 ? 1'b1 : ((wr_en || other_acc) ? 1'b0 : armed);
      req_q <= under || feed_bad;
      if (under || feed_bad) flag_q <= 1'b1;
      if (feed_ok) begin
        cnt      <= load;
        pre      <= '0;
        ctrl_act <= ctrl_pend;
      end else if (under) begin
        cnt <= load;
        pre <= '0;
      end else if (run) begin
        pre <= pre + PRE_W'(1);
        if (tick) cnt <= cnt - 8'd1;
      end
    end
  end

  assign sys_rst_req  = req_q;
  assign timeout_flag = flag_q;
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int PRE_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [7:0]       wr_data,
  input logic             sys_rst_req,
  input logic             timeout_flag,
  input logic             armed,
  input logic [7:0]       cnt,
  input logic [7:0]       load,
  input logic [7:0]       ctrl_act,
  input logic [PRE_W-1:0] pre
);
  wire good2 = armed && wr_en && wr_addr == 2'd3 && wr_data == 8'h5A;
  wire bad2  = armed && wr_en && wr_addr == 2'd3 && wr_data != 8'h5A;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |=> timeout_flag); // R4
  AST_REQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> timeout_flag); // R4
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> (cnt == $past(cnt) - 8'd1) || (cnt == $past(load))); // R3
  AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    bad2 |=> sys_rst_req); // R8
  AST_FEED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    good2 |=> (pre == '0) && !sys_rst_req); // R5
  AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !good2 |=> $stable(ctrl_act)); // R6
  AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_act[7] && !good2) |=> $stable(cnt) && $stable(pre)); // R7
endmodule

bind wdog_keyed wdog_keyed_chk #(.PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .sys_rst_req(sys_rst_req), .timeout_flag(timeout_flag), .armed(armed),
  .cnt(cnt), .load(load), .ctrl_act(ctrl_act), .pre(pre)
);

// File: tb/wdog_keyed_tb_top.sv
module wdog_keyed_tb_top;
  localparam int BL = 1;
  logic clk = 0, rst_n = 0, wr_en = 0, other_acc = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic sys_rst_req, timeout_flag;
  int vectors = 0, miscompares = 0, cycles = 0;
  bit done = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  wdog_keyed #(.BASE_LOG(BL)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .other_acc(other_acc), .sys_rst_req(sys_rst_req), .timeout_flag(timeout_flag));

  // behavioural reference
  int m_pre, m_cnt, m_load, m_ca, m_cp, m_div;
  bit m_armed, m_req, m_flag, m_run, m_tick, m_ok, m_bad, m_under;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_load = 0; m_ca = 'h87; m_cp = 'h87;
      m_armed = 0; m_req = 0; m_flag = 0;
    end else begin
      m_run  = m_ca[7];
      m_div  = 1 << (BL + (m_ca & 7));
      m_tick = m_run && (m_pre % m_div == m_div - 1);
      m_ok   = m_armed && wr_en && wr_addr == 3 && wr_data == 8'h5A;
      m_bad  = m_armed && wr_en && wr_addr == 3 && wr_data != 8'h5A;
      m_under = m_tick && m_cnt == 0 && !m_ok;
      m_req = m_under || m_bad;
      if (m_req) m_flag = 1;
      if (m_ok) begin m_cnt = m_load; m_pre = 0; m_ca = m_cp; end
      else if (m_under) begin m_cnt = m_load; m_pre = 0; end
      else if (m_run) begin m_pre++; if (m_tick) m_cnt--; end
      if (wr_en && wr_addr == 0) m_cp = wr_data;
      if (wr_en && wr_addr == 1) m_load = wr_data;
      if (wr_en && wr_addr == 2 && wr_data == 8'hA5) m_armed = 1;
      else if (wr_en || other_acc) m_armed = 0;
    end
  end

  always @(negedge clk) if (!done) begin
    vectors++;
    if (sys_rst_req !== m_req) begin
      miscompares++;
      $display("FAIL %s sys_rst_req actual=%b expected=%b t=%0t", phase, sys_rst_req, m_req, $time);
    end
    if (timeout_flag !== m_flag) begin
      miscompares++;
      $display("FAIL %s timeout_flag actual=%b expected=%b t=%0t", phase, timeout_flag, m_flag, $time);
    end
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog expired in %s", phase);
      finish_run();
    end
  end

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic acc(input logic we, input logic [1:0] a, input logic [7:0] d, input logic oth);
    wr_en = we; wr_addr = a; wr_data = d; other_acc = oth;
    @(posedge clk); #1;
    wr_en = 0; other_acc = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic feed();
    acc(1, 2, 8'hA5, 0);
    acc(1, 3, 8'h5A, 0);
  endtask

  initial begin
    phase = "R1";
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    phase = "R3";                       // default: divisor 256, autoload 0
    idle(600);
    phase = "R6";                       // staged values not yet active
    acc(1, 0, 8'h81, 0);
    acc(1, 1, 8'd3, 0);
    idle(300);
    phase = "R5";
    feed();
    idle(60);
    phase = "R2";
    for (int s = 0; s < 8; s++) begin
      acc(1, 0, 8'h80 | 8'(s), 0);
      acc(1, 1, 8'd1, 0);
      feed();
      idle((4 << (BL + s)) + 5);
    end
    phase = "R8";
    acc(1, 0, 8'h80, 0);
    acc(1, 1, 8'd40, 0);
    feed();
    idle(10);
    acc(1, 2, 8'hA5, 0);
    acc(1, 3, 8'h33, 0);
    idle(10);
    phase = "R9";
    acc(1, 2, 8'hA5, 0); acc(0, 0, 8'h00, 1); acc(1, 3, 8'h5A, 0);
    idle(5);
    acc(1, 2, 8'hA5, 0); acc(1, 1, 8'd40, 0); acc(1, 3, 8'h12, 0);
    idle(5);
    acc(1, 2, 8'hA5, 0); acc(1, 2, 8'h11, 0); acc(1, 3, 8'h00, 0);
    idle(5);
    acc(1, 2, 8'hA5, 0); idle(3); acc(1, 3, 8'h5A, 0);   // idle cycles keep it armed
    idle(5);
    phase = "R10";
    acc(1, 3, 8'h00, 0);
    acc(1, 3, 8'h5A, 0);
    idle(120);
    phase = "R11";
    acc(1, 1, 8'd0, 0);
    for (int k = 0; k < 12; k++) begin
      feed();
      idle(k);
    end
    idle(20);
    phase = "R7";
    acc(1, 0, 8'h00, 0);
    feed();
    idle(400);
    acc(1, 2, 8'hA5, 0); acc(1, 3, 8'hFF, 0);           // bad key still resets when stopped
    idle(5);
    acc(1, 0, 8'h80, 0);
    feed();
    idle(15);
    phase = "R4";
    rst_n = 0;                          // reset on top of a running timer
    idle(3);
    rst_n = 1;
    phase = "R1";
    idle(2);
    phase = "R4";
    acc(1, 0, 8'h80, 0);
    acc(1, 1, 8'd2, 0);
    feed();
    idle(5);                            // counter 2 at divisor 2: underflow at 6th edge
    rst_n = 0;
    idle(2);
    rst_n = 1;
    idle(600);
    finish_run();
  end
endmodule